// File: doc/BRIEF.md
# Destination Address Hash Filter

This block gives an imperfect accept/reject verdict for a received Ethernet frame from its 48-bit destination address. The six address bytes arrive as a byte stream, first byte first, qualified by a valid strobe, with a start strobe marking the first byte. A CRC-32 runs over those bytes. The top bits of the CRC register pick one bit in one of two banks of software-written 32-bit hash registers. A set bit enables a bucket that usually covers many addresses, so a hit may be a false positive that later logic or software filters out.

In normal mode the first bank is a 256-bucket table for individual (unicast) destinations and the second bank is a 256-bucket table for group (multicast) destinations. In extended mode the two banks join into one 512-bucket group table, and individual destinations never hit. A register write port loads the banks. The verdict appears on `res_hit` with a one-cycle `res_done` pulse.

Top module: `dahash_filter`

## Requirements
- R1: At the first byte of a frame the CRC register is seeded with 0xFFFFFFFF. Each accepted byte is folded in least significant bit first using the reflected polynomial 0xEDB88320. The index is taken from the final register value with no inversion: bits [31:24] in normal mode and bits [31:23] in extended mode.
- R2: A byte is accepted on a clock edge where `da_valid`=1. A byte with `da_sof`=1 is the first address byte. Valid bytes that arrive while no frame is open (before any start, or after the sixth byte) are ignored and produce no result.
- R3: `res_done` is high for exactly one cycle, in the cycle after the sixth byte is accepted. `res_hit` carries the verdict in that cycle and is 0 in every other cycle.
- R4: In normal mode (`ext_mode`=0), a destination whose first byte has bit 0 = 0 (individual) looks up the 8-bit index in bank 0 (`wr_bank`=0).
- R5: In normal mode, a destination whose first byte has bit 0 = 1 (group) looks up the 8-bit index in bank 1 (`wr_bank`=1).
- R6: In extended mode, a group destination uses the 9-bit index n. Buckets 0..255 are in bank 0 and buckets 256..511 are in bank 1, at bucket n-256.
- R7: In extended mode, an individual destination always gives `res_hit`=0, whatever the banks hold.
- R8: Bucket e (0..255) of a bank lives in register `wr_addr`=e/32, at bit 31-(e mod 32). A hit requires that bit to be 1. A cleared bit gives a miss even when every other bit is set.
- R9: Reset clears all hash registers and both outputs, so no lookup hits until a register is written.
- R10: A new start strobe abandons any partial frame. No result is produced for the abandoned bytes, and the new frame is evaluated from a fresh seed.
- R11: `ext_mode` is sampled with the start byte. Changing it later in the same frame does not alter that frame's verdict.
- R12: A write with `wr_en`=1 replaces the whole selected register at that clock edge. A lookup that completes on the same edge still sees the old contents, and later lookups see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| da_valid | input | 1 | Address byte valid |
| da_sof | input | 1 | Marks the first address byte of a frame |
| da_byte | input | 8 | Address byte, first transmitted byte first |
| ext_mode | input | 1 | 0: split unicast/multicast tables, 1: one 512-bucket group table |
| wr_en | input | 1 | Hash register write enable |
| wr_bank | input | 1 | Bank selected for writing |
| wr_addr | input | 3 | Register index within the bank |
| wr_data | input | 32 | Data written to the register |
| res_done | output | 1 | One-cycle pulse marking a finished lookup |
| res_hit | output | 1 | Lookup verdict, valid while res_done is high |

## Verification
The bench builds the filter with its default parameters: six address bytes and two banks of eight 32-bit registers. With these values every one of the 512 buckets, both banks and the full 9-bit index can be reached. For each vector, the bench computes the CRC itself and places a lone set bit, or a lone cleared bit, at the predicted bucket. This checks the bucket-to-bit mapping in both directions under both modes. Directed runs cover stray bytes outside a frame, an abandoned partial frame, a mode flip in mid-frame, and a write landing on the same edge as the final byte.

// File: rtl/dahash_pkg.sv
package dahash_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_e;
endpackage

// File: rtl/dahash_rst_sync.sv
module dahash_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dahash_crc.sv
module dahash_crc
  import dahash_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              seed_sel,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_nxt
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] acc;

  // one byte per step, least significant bit first, reflected register
  always_comb begin
    acc = seed_sel ? CRC_SEED : crc_q;
    for (int k = 0; k < BYTE_W; k++) begin
      if (acc[0] ^ din[k]) acc = (acc >> 1) ^ CRC_POLY_REFL;
      else                 acc = acc >> 1;
    end
    crc_nxt = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= CRC_SEED;
    else if (step_en) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/dahash_ctrl.sv
module dahash_ctrl #(
  parameter  int NBYTES = 6,
  localparam int CNT_W  = $clog2(NBYTES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_vld,
  input  logic byte_sof,
  input  logic first_lsb,
  input  logic mode_in,
  output logic crc_step,
  output logic crc_seed,
  output logic last_acc,
  output logic mode_eff,
  output logic grp_eff
);
  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q, mode_d;
  logic             grp_q, grp_d;
  logic             start, cont;

  always_comb begin
    start    = byte_vld & byte_sof;
    cont     = byte_vld & ~byte_sof & active_q;
    crc_step = start | cont;
    crc_seed = start;
    last_acc = (start & (NBYTES == 1)) |
               (cont & (cnt_q == CNT_W'(NBYTES - 1)));
    mode_eff = start ? mode_in   : mode_q;
    grp_eff  = start ? first_lsb : grp_q;

    active_d = active_q;
    cnt_d    = cnt_q;
    mode_d   = mode_q;
    grp_d    = grp_q;
    if (start) begin
      active_d = (NBYTES > 1);
      cnt_d    = CNT_W'(1);
      mode_d   = mode_in;
      grp_d    = first_lsb;
    end else if (cont) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (last_acc) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      mode_q   <= 1'b0;
      grp_q    <= 1'b0;
    end else if (crc_step) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      mode_q   <= mode_d;
      grp_q    <= grp_d;
    end
  end
endmodule

// File: rtl/dahash_table.sv
module dahash_table #(
  parameter  int NREGS = 8,
  parameter  int RW    = 32,
  localparam int AW    = $clog2(NREGS),
  localparam int BW    = $clog2(RW),
  localparam int EW    = AW + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [EW-1:0] rd_entry,
  output logic          rd_bit
);
  logic [RW-1:0] regs [2*NREGS];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar r = 0; r < NREGS; r++) begin : g_reg
      logic [RW-1:0] reg_q;
      logic          reg_we;

      assign reg_we = wr_en & (wr_bank == 1'(b)) & (wr_addr == AW'(r));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_q <= '0;
        else if (reg_we) reg_q <= wr_data;
      end

      assign regs[b*NREGS + r] = reg_q;
    end
  end

  logic [RW-1:0] rd_word;
  logic [BW-1:0] bit_sel;

  // lowest bucket of a register sits in its top bit
  always_comb begin
    rd_word = regs[{rd_bank, rd_entry[EW-1:BW]}];
    bit_sel = BW'(RW - 1) - rd_entry[BW-1:0];
    rd_bit  = rd_word[bit_sel];
  end
endmodule

// File: rtl/dahash_filter.sv
module dahash_filter
  import dahash_pkg::*;
#(
  parameter  int DA_BYTES = 6,
  parameter  int TBL_REGS = 8,
  parameter  int REG_W    = 32,
  localparam int WA_W     = $clog2(TBL_REGS),
  localparam int ENTRY_W  = $clog2(TBL_REGS * REG_W),
  localparam int IDX_W    = ENTRY_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              da_valid,
  input  logic              da_sof,
  input  logic [BYTE_W-1:0] da_byte,
  input  logic              ext_mode,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [WA_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic              res_done,
  output logic              res_hit
);
  logic             srst_n;
  logic             crc_step, crc_seed, last_acc, mode_eff, grp_eff;
  logic [CRC_W-1:0] crc_nxt;
  logic [IDX_W-1:0] idx;
  bank_e            rd_bank;
  logic [ENTRY_W-1:0] rd_entry;
  logic             rd_bit, allow;
  logic             done_d, hit_d;

  dahash_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dahash_ctrl #(.NBYTES(DA_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .byte_vld  (da_valid),
    .byte_sof  (da_sof),
    .first_lsb (da_byte[0]),
    .mode_in   (ext_mode),
    .crc_step  (crc_step),
    .crc_seed  (crc_seed),
    .last_acc  (last_acc),
    .mode_eff  (mode_eff),
    .grp_eff   (grp_eff)
  );

  dahash_crc u_crc (
    .clk     (clk),
    .rst_n   (srst_n),
    .step_en (crc_step),
    .seed_sel(crc_seed),
    .din     (da_byte),
    .crc_nxt (crc_nxt)
  );

  // index comes from the register value after the last byte, not inverted
  always_comb begin
    idx = crc_nxt[CRC_W-1 -: IDX_W];
    if (mode_eff) begin
      rd_bank  = bank_e'(idx[IDX_W-1]);
      rd_entry = idx[ENTRY_W-1:0];
      allow    = grp_eff;
    end else begin
      rd_bank  = grp_eff ? BANK_HI : BANK_LO;
      rd_entry = idx[IDX_W-1:1];
      allow    = 1'b1;
    end
    done_d = last_acc;
    hit_d  = last_acc & allow & rd_bit;
  end

  dahash_table #(.NREGS(TBL_REGS), .RW(REG_W)) u_tbl (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (wr_en),
    .wr_bank  (wr_bank),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_bank  (rd_bank),
    .rd_entry (rd_entry),
    .rd_bit   (rd_bit)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      res_done <= 1'b0;
      res_hit  <= 1'b0;
    end else begin
      res_done <= done_d;
      res_hit  <= hit_d;
    end
  end
endmodule

// File: rtl/dahash_filter_chk.sv
module dahash_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic da_valid,
  input logic da_sof,
  input logic res_done,
  input logic res_hit
);
  // R3: the done strobe never lasts two cycles
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  // R3: a verdict is only shown together with done
  a_r3_hit_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> !res_hit);

  // R2: a result always follows an accepted byte
  a_r2_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> $past(da_valid));

  // R10: a start byte opens a frame, so no result can follow it directly
  a_r10_sof_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da_sof) |=> !res_done);
endmodule

bind dahash_filter dahash_filter_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .da_valid (da_valid),
  .da_sof   (da_sof),
  .res_done (res_done),
  .res_hit  (res_hit)
);

// File: tb/dahash_filter_tb_top.sv
`timescale 1ns/1ps
module dahash_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        da_valid, da_sof, ext_mode;
  logic [7:0]  da_byte;
  logic        wr_en, wr_bank;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        res_done, res_hit;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dahash_filter dut_i (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_sof(da_sof),
    .da_byte(da_byte), .ext_mode(ext_mode), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .res_done(res_done), .res_hit(res_hit)
  );

  // {ext, set, address}; set=1 places a lone 1, set=0 a lone 0, at the bucket
  localparam logic [49:0] VEC [0:7] = '{
    {1'b0, 1'b1, 48'h001B213A4C5D},
    {1'b0, 1'b1, 48'h01005E0000FB},
    {1'b1, 1'b1, 48'h01005E7FFFFA},
    {1'b1, 1'b1, 48'h333300000001},
    {1'b0, 1'b0, 48'hFFFFFFFFFFFF},
    {1'b1, 1'b1, 48'h02AABBCCDDEE},
    {1'b1, 1'b0, 48'h0180C200000E},
    {1'b0, 1'b1, 48'h000000000000}
  };

  logic got_done, got_hit, early_done;
  logic lw_en, lw_bank;
  logic [2:0]  lw_addr;
  logic [31:0] lw_data;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = a[47-8*i -: 8];
      for (int k = 0; k < 8; k++)
        c = (c[0] ^ b[k]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  // bank, register and bit for an address under a mode
  task automatic locate(input logic [47:0] a, input bit ext,
                        output bit bank, output logic [2:0] ra, output int bitpos);
    logic [31:0] c = ref_crc(a);
    logic [8:0]  n = c[31:23];
    logic [7:0]  e;
    if (ext) begin bank = n[8]; e = n[7:0]; end
    else     begin bank = a[40]; e = n[8:1]; end
    ra = e[7:5];
    bitpos = 31 - int'(e[4:0]);
  endtask

  task automatic wr_reg(input bit b, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = b; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 8; r++) wr_reg(b[0], r[2:0], 32'h0);
  endtask

  // drives n bytes; optional mid-frame mode flip and a write on the last byte
  task automatic send(input logic [47:0] a, input bit ext, input int n,
                      input bit flip, input bit sof_first);
    early_done = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0 && res_done) early_done = 1'b1;
      da_valid = 1'b1;
      da_sof   = sof_first && (i == 0);
      da_byte  = a[47-8*i -: 8];
      ext_mode = (flip && i > 0) ? ~ext : ext;
      if (i == n - 1 && lw_en) begin
        wr_en = 1'b1; wr_bank = lw_bank; wr_addr = lw_addr; wr_data = lw_data;
      end
    end
    @(negedge clk);
    da_valid = 1'b0; da_sof = 1'b0; wr_en = 1'b0;
    got_done = res_done;
    got_hit  = res_hit;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit b; logic [2:0] ra; int bp; bit exp_hit; string tag;
    rst_n = 1'b0; da_valid = 1'b0; da_sof = 1'b0; da_byte = 8'h0; ext_mode = 1'b0;
    wr_en = 1'b0; wr_bank = 1'b0; wr_addr = 3'h0; wr_data = 32'h0; lw_en = 1'b0;
    lw_bank = 1'b0; lw_addr = 3'h0; lw_data = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state, then a lookup on empty banks
    check(res_done == 1'b0 && res_hit == 1'b0, "R9 reset outputs", res_done, 0);
    send(VEC[0][47:0], 1'b0, 6, 1'b0, 1'b1);
    check(got_done == 1'b1, "R3 done after reset lookup", got_done, 1);
    check(got_hit == 1'b0, "R9 empty banks miss", got_hit, 0);

    // vector table: R1 index, R4..R8 bank and bit placement
    for (int v = 0; v < 8; v++) begin
      logic [47:0] a = VEC[v][47:0];
      bit ext = VEC[v][49];
      bit set = VEC[v][48];
      clear_all();
      locate(a, ext, b, ra, bp);
      wr_reg(b, ra, set ? (32'h1 << bp) : ~(32'h1 << bp));
      send(a, ext, 6, 1'b0, 1'b1);
      exp_hit = set && !(ext && !a[40]);
      if (ext && !a[40]) tag = "R7";
      else if (ext)      tag = "R6/R8/R1";
      else if (a[40])    tag = "R5/R8/R1";
      else               tag = "R4/R8/R1";
      check(got_done == 1'b1, "R3 done pulse", got_done, 1);
      check(got_hit == exp_hit, tag, got_hit, exp_hit);
      @(negedge clk);
      check(res_done == 1'b0 && res_hit == 1'b0, "R3 single cycle", res_done, 0);
    end

    // R2: stray bytes with no start give nothing
    send(VEC[1][47:0], 1'b0, 6, 1'b0, 1'b0);
    check(got_done == 1'b0 && early_done == 1'b0, "R2 stray bytes ignored", got_done, 0);

    // R10: partial frame abandoned by a new start
    clear_all();
    locate(VEC[1][47:0], 1'b0, b, ra, bp);
    wr_reg(b, ra, 32'h1 << bp);
    send(VEC[4][47:0], 1'b0, 3, 1'b0, 1'b1);
    check(got_done == 1'b0, "R10 no result for partial", got_done, 0);
    send(VEC[1][47:0], 1'b0, 6, 1'b0, 1'b1);
    check(got_done == 1'b1 && got_hit == 1'b1, "R10 restart verdict", got_hit, 1);

    // R11: mode flipped after the start byte is not used
    clear_all();
    locate(VEC[2][47:0], 1'b1, b, ra, bp);
    wr_reg(b, ra, 32'h1 << bp);
    send(VEC[2][47:0], 1'b1, 6, 1'b1, 1'b1);
    check(got_done == 1'b1 && got_hit == 1'b1, "R11 mode held for frame", got_hit, 1);

    // R12: a write on the final byte's edge is seen only by the next lookup
    clear_all();
    locate(VEC[1][47:0], 1'b0, b, ra, bp);
    lw_en = 1'b1; lw_bank = b; lw_addr = ra; lw_data = 32'h1 << bp;
    send(VEC[1][47:0], 1'b0, 6, 1'b0, 1'b1);
    lw_en = 1'b0;
    check(got_done == 1'b1 && got_hit == 1'b0, "R12 same-edge write unseen", got_hit, 0);
    send(VEC[1][47:0], 1'b0, 6, 1'b0, 1'b1);
    check(got_hit == 1'b1, "R12 write seen next lookup", got_hit, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule